// File: doc/BRIEF.md
# Diagnostic Window Register Bridge

This block sits on the target side of a chip and gives an external host a path into the internal 32-bit memory bus without any help from the target processor. The host sees a small set of byte-wide registers: two four-byte address windows (one for reads, one for writes), a four-byte data window, a status byte, a debug-select byte and a four-byte debug view. The internal side is a single-word request/acknowledge master.

The host arms an access by loading the upper three bytes of an address window. These writes only store bits; nothing happens on the internal bus. The write to byte 0 of a window stores the low address bits and launches exactly one internal cycle. A read cycle places the returned word in the data window. For a write cycle the host loads the data window first, then fires the write window, and the word held at that moment is sent. A busy bit covers the time from launch to acknowledge. A launch attempted while busy is dropped and raises a sticky overrun flag. The debug view returns one word of an external register bank, chosen by the select byte.

Top module: `diag_window_bridge`

## Requirements
- R1: A write to byte 1, 2 or 3 of either address window (read window at 0x47C..0x47F, write window at 0x478..0x47B) stores that byte into bits 8k+7:8k of the window, can be read back at the same offset, and starts no internal cycle.
- R2: A write to byte 0 of an address window while idle stores bits 7:0 and starts exactly one internal cycle. mst_addr carries the full 32-bit window value, with the new byte 0 included.
- R3: A read-window launch drives mst_we=0. The acknowledged mst_rdata is captured into the data window on the acknowledge clock. It reads back little-endian at 0x474..0x477, with offset 0x474+k returning bits 8k+7:8k.
- R4: A write-window launch drives mst_we=1, with mst_wdata equal to the data window contents (loaded little-endian at 0x474..0x477) at the moment of the launch.
- R5: Repeated fixed-address writes of one value to an upper address byte have no effect beyond storing that value. Every write to byte 0 while idle starts exactly one cycle.
- R6: A four-byte ascending write of an address window whose upper bytes already hold the same values starts exactly one cycle, to the full written address.
- R7: Status bit 0 (offset 0x480) reads 1 from the launch until the acknowledge, and mst_req stays high with a stable address for that whole time.
- R8: A byte-0 write while busy starts no cycle and leaves byte 0 unchanged. It sets status bit 1, which stays set until a host write to 0x480 with bit 1 equal to 1; writing 0 there leaves it set.
- R9: While busy, reads of the data window return the data held before the launch.
- R10: The select byte at 0x483 picks bank entry N. Offsets 0x484+k return bits 8k+7:8k of entry N, or zero when N is at least the bank size. Writing one index four times leaves the select equal to it.
- R11: After reset all windows, the select byte, busy and overrun read zero and mst_req is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hst_addr | input | ADDR_W | Host byte offset |
| hst_wr | input | 1 | Host write strobe, one byte per cycle |
| hst_rd | input | 1 | Host read strobe; hst_rdata updates on the next clock |
| hst_wdata | input | 8 | Host write byte |
| hst_rdata | output | 8 | Host read byte (registered) |
| mst_req | output | 1 | Internal cycle request, held until acknowledge |
| mst_we | output | 1 | 1 = write cycle, 0 = read cycle |
| mst_addr | output | 32 | Internal word address |
| mst_wdata | output | 32 | Internal write word |
| mst_ack | input | 1 | Internal acknowledge, one cycle |
| mst_rdata | input | 32 | Internal read word, valid with mst_ack |
| dbg_bank | input | DBG_N*32 | External debug register bank, entry i at bits 32i+31:32i |

## Verification
The hardest case to reach is the window between launch and acknowledge. A second byte-0 write, a data-window read and a status read must all land there while the request is still open. The bench's memory model holds the acknowledge back for a fixed number of cycles, which keeps the in-flight period long enough. The stimulus then issues the overrun attempt and the stale-data read back to back right after the launch, and compares against values computed from the address.

// File: rtl/diag_win_pkg.sv
// Package: register offsets shared by the bridge and its bench.
// Assumes window bases are four-byte aligned so bits 1:0 select the lane.
package diag_win_pkg;
    localparam int unsigned OFS_DATA   = 'h474;
    localparam int unsigned OFS_WRADDR = 'h478;
    localparam int unsigned OFS_RDADDR = 'h47C;
    localparam int unsigned OFS_STATUS = 'h480;
    localparam int unsigned OFS_DBGSEL = 'h483;
    localparam int unsigned OFS_DBGVAL = 'h484;
endpackage

// File: rtl/diag_addr_window.sv
// Module: one four-byte address window.
// Upper lanes latch on any write. Lane 0 latches only when not blocked, and a
// lane-0 write raises fire for that cycle. target is the address the launch
// uses: the stored upper bytes joined with the byte being written.
module diag_addr_window #(
    parameter int unsigned        ADDR_W = 12,
    parameter logic [ADDR_W-1:0]  BASE   = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              blocked,
    output logic [31:0]       value,
    output logic [31:0]       target,
    output logic              fire
);
    logic hit;
    assign hit    = wr_en && (addr[ADDR_W-1:2] == BASE[ADDR_W-1:2]);
    assign fire   = hit && (addr[1:0] == 2'd0);
    assign target = {value[31:8], wdata};

    for (genvar k = 0; k < 4; k++) begin : g_lane
        // Purpose: store one byte lane of the window.
        always_ff @(posedge clk) begin
            if (!rst_n)
                value[8*k +: 8] <= 8'h00;
            else if (hit && addr[1:0] == 2'(k) && (k != 0 || !blocked))
                value[8*k +: 8] <= wdata;
        end
    end

    // R8: a blocked lane-0 write must not disturb the stored low byte.
    p_lane0_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && blocked) |=> $stable(value[7:0]));
endmodule

// File: rtl/diag_dbg_view.sv
// Module: debug-select byte and the word view of the external bank.
// An index at or above DBG_N selects an all-zero word.
module diag_dbg_view #(
    parameter int unsigned DBG_N = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_we,
    input  logic [7:0]        sel_wdata,
    input  logic [DBG_N*32-1:0] bank,
    output logic [7:0]        sel,
    output logic [31:0]       word
);
    // Purpose: hold the selection index.
    always_ff @(posedge clk) begin
        if (!rst_n)      sel <= 8'h00;
        else if (sel_we) sel <= sel_wdata;
    end

    // Purpose: pick the selected bank entry.
    always_comb begin
        word = 32'h0;
        for (int i = 0; i < DBG_N; i++)
            if (32'(sel) == i) word = bank[32*i +: 32];
    end

    // R10: the index follows the last write.
    p_sel_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sel_we |=> (sel == $past(sel_wdata)));
endmodule

// File: rtl/diag_xfer_ctrl.sv
// Module: internal cycle engine and data window.
// Assumes at most one window fires per cycle and that mst_ack only comes while
// a request is open. Capture of read data takes priority over a host write of
// the data window in the same cycle.
module diag_xfer_ctrl (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rd_fire,
    input  logic        wr_fire,
    input  logic [31:0] rd_target,
    input  logic [31:0] wr_target,
    input  logic        data_we,
    input  logic [1:0]  data_lane,
    input  logic [7:0]  data_byte,
    input  logic        ovr_clr,
    input  logic        mst_ack,
    input  logic [31:0] mst_rdata,
    output logic        busy,
    output logic        ovr,
    output logic [31:0] data_q,
    output logic        mst_req,
    output logic        mst_we,
    output logic [31:0] mst_addr,
    output logic [31:0] mst_wdata
);
    logic any_fire, start, done;
    assign any_fire = rd_fire || wr_fire;
    assign busy     = mst_req;
    assign start    = any_fire && !busy;
    assign done     = mst_req && mst_ack;

    // Purpose: open a request on launch and close it on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mst_req   <= 1'b0;
            mst_we    <= 1'b0;
            mst_addr  <= 32'h0;
            mst_wdata <= 32'h0;
        end else if (start) begin
            mst_req   <= 1'b1;
            mst_we    <= wr_fire;
            mst_addr  <= wr_fire ? wr_target : rd_target;
            mst_wdata <= data_q;
        end else if (done) begin
            mst_req   <= 1'b0;
        end
    end

    // Purpose: data window, loaded by the host or by a read acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            data_q <= 32'h0;
        else if (done && !mst_we)
            data_q <= mst_rdata;
        else if (data_we)
            data_q[8*data_lane +: 8] <= data_byte;
    end

    // Purpose: sticky overrun, set by a launch while busy, cleared by write-one.
    always_ff @(posedge clk) begin
        if (!rst_n)                ovr <= 1'b0;
        else if (any_fire && busy) ovr <= 1'b1;
        else if (ovr_clr)          ovr <= 1'b0;
    end

    p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_req && !mst_ack) |=> (mst_req && $stable(mst_addr) && $stable(mst_we)));
    p_wdata_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_req && !mst_ack) |=> $stable(mst_wdata));
    p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_req && mst_ack && !mst_we) |=> (data_q == $past(mst_rdata)));
    p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !ovr_clr) |=> ovr);
    p_ack_closes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_req && mst_ack) |=> !mst_req);
endmodule

// File: rtl/diag_window_bridge.sv
// Module: top of the diagnostic window bridge.
// Decodes the host byte port, instantiates both address windows, the cycle
// engine and the debug view, and registers the host read byte.
module diag_window_bridge #(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DBG_N  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   hst_addr,
    input  logic                hst_wr,
    input  logic                hst_rd,
    input  logic [7:0]          hst_wdata,
    output logic [7:0]          hst_rdata,
    output logic                mst_req,
    output logic                mst_we,
    output logic [31:0]         mst_addr,
    output logic [31:0]         mst_wdata,
    input  logic                mst_ack,
    input  logic [31:0]         mst_rdata,
    input  logic [DBG_N*32-1:0] dbg_bank
);
    import diag_win_pkg::*;

    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
    localparam logic [ADDR_W-1:0] A_WRA  = ADDR_W'(OFS_WRADDR);
    localparam logic [ADDR_W-1:0] A_RDA  = ADDR_W'(OFS_RDADDR);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_SEL  = ADDR_W'(OFS_DBGSEL);
    localparam logic [ADDR_W-1:0] A_DBG  = ADDR_W'(OFS_DBGVAL);

    logic        busy, ovr, rd_fire, wr_fire;
    logic [31:0] rd_val, wr_val, rd_tgt, wr_tgt, data_q, dbg_word;
    logic [7:0]  sel;
    logic [7:0]  rd_mux;
    logic [ADDR_W-3:0] grp;
    assign grp = hst_addr[ADDR_W-1:2];

    diag_addr_window #(.ADDR_W(ADDR_W), .BASE(A_RDA)) u_rd_win (
        .clk(clk), .rst_n(rst_n), .wr_en(hst_wr), .addr(hst_addr),
        .wdata(hst_wdata), .blocked(busy), .value(rd_val),
        .target(rd_tgt), .fire(rd_fire));

    diag_addr_window #(.ADDR_W(ADDR_W), .BASE(A_WRA)) u_wr_win (
        .clk(clk), .rst_n(rst_n), .wr_en(hst_wr), .addr(hst_addr),
        .wdata(hst_wdata), .blocked(busy), .value(wr_val),
        .target(wr_tgt), .fire(wr_fire));

    diag_xfer_ctrl u_xfer (
        .clk(clk), .rst_n(rst_n), .rd_fire(rd_fire), .wr_fire(wr_fire),
        .rd_target(rd_tgt), .wr_target(wr_tgt),
        .data_we(hst_wr && grp == A_DATA[ADDR_W-1:2]),
        .data_lane(hst_addr[1:0]), .data_byte(hst_wdata),
        .ovr_clr(hst_wr && hst_addr == A_STAT && hst_wdata[1]),
        .mst_ack(mst_ack), .mst_rdata(mst_rdata),
        .busy(busy), .ovr(ovr), .data_q(data_q),
        .mst_req(mst_req), .mst_we(mst_we),
        .mst_addr(mst_addr), .mst_wdata(mst_wdata));

    diag_dbg_view #(.DBG_N(DBG_N)) u_dbg (
        .clk(clk), .rst_n(rst_n),
        .sel_we(hst_wr && hst_addr == A_SEL), .sel_wdata(hst_wdata),
        .bank(dbg_bank), .sel(sel), .word(dbg_word));

    // Purpose: choose the byte a host read returns.
    always_comb begin
        rd_mux = 8'h00;
        if (grp == A_DATA[ADDR_W-1:2])     rd_mux = data_q[8*hst_addr[1:0] +: 8];
        else if (grp == A_WRA[ADDR_W-1:2]) rd_mux = wr_val[8*hst_addr[1:0] +: 8];
        else if (grp == A_RDA[ADDR_W-1:2]) rd_mux = rd_val[8*hst_addr[1:0] +: 8];
        else if (grp == A_DBG[ADDR_W-1:2]) rd_mux = dbg_word[8*hst_addr[1:0] +: 8];
        else if (hst_addr == A_STAT)       rd_mux = {6'b0, ovr, busy};
        else if (hst_addr == A_SEL)        rd_mux = sel;
    end

    // Purpose: register the host read byte on the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      hst_rdata <= 8'h00;
        else if (hst_rd) hst_rdata <= rd_mux;
    end

    // R1: an upper-lane window write while idle opens no request.
    p_upper_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_wr && hst_addr[1:0] != 2'd0 && !mst_req &&
         (grp == A_RDA[ADDR_W-1:2] || grp == A_WRA[ADDR_W-1:2])) |=> !mst_req);
    // R2: a lane-0 launch while idle opens a request to the full target.
    p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fire && !mst_req) |=> (mst_req && !mst_we && mst_addr == $past(rd_tgt)));
endmodule

// File: tb/diag_window_bridge_tb.sv
module diag_window_bridge_tb;
    localparam int AW = 12;
    localparam int DN = 8;
    localparam int LAT = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] hst_addr = '0;
    logic hst_wr = 1'b0, hst_rd = 1'b0;
    logic [7:0] hst_wdata = 8'h00;
    logic [7:0] hst_rdata;
    logic mst_req, mst_we, mst_ack = 1'b0;
    logic [31:0] mst_addr, mst_wdata, mst_rdata = 32'h0;
    logic [DN*32-1:0] dbg_bank;

    int n_chk = 0, n_bad = 0, trig_cnt = 0, lat_cnt = 0, cycles = 0;
    logic prev_req = 1'b0;
    logic [31:0] last_addr = 32'h0, last_wdata = 32'h0;
    logic last_we = 1'b0;

    always #4 clk = ~clk;

    for (genvar i = 0; i < DN; i++) begin : g_bank
        assign dbg_bank[32*i +: 32] = 32'h1000_0001 * (i + 3) ^ 32'hC0DE_0000;
    end

    diag_window_bridge #(.ADDR_W(AW), .DBG_N(DN)) u_dut (
        .clk(clk), .rst_n(rst_n), .hst_addr(hst_addr), .hst_wr(hst_wr),
        .hst_rd(hst_rd), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
        .mst_req(mst_req), .mst_we(mst_we), .mst_addr(mst_addr),
        .mst_wdata(mst_wdata), .mst_ack(mst_ack), .mst_rdata(mst_rdata),
        .dbg_bank(dbg_bank));

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {a[7:0], a[15:8], a[23:16], a[31:24]} ^ 32'h5A3C_96E1;
    endfunction

    function automatic logic [31:0] bank_word(input int i);
        return (i < DN) ? (32'h1000_0001 * (i + 3) ^ 32'hC0DE_0000) : 32'h0;
    endfunction

    // Memory model: count launches, acknowledge after LAT cycles.
    always @(negedge clk) begin
        cycles <= cycles + 1;
        if (mst_req && !prev_req) begin
            trig_cnt   <= trig_cnt + 1;
            last_addr  <= mst_addr;
            last_we    <= mst_we;
            last_wdata <= mst_wdata;
        end
        prev_req <= mst_req;
        if (mst_ack) begin
            mst_ack <= 1'b0;
            lat_cnt <= 0;
        end else if (mst_req) begin
            if (lat_cnt == LAT) begin
                mst_ack   <= 1'b1;
                mst_rdata <= mem_word(mst_addr);
            end else lat_cnt <= lat_cnt + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        hst_addr = AW'(a); hst_wdata = d; hst_wr = 1'b1;
        @(negedge clk);
        hst_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [7:0] d);
        @(negedge clk);
        hst_addr = AW'(a); hst_rd = 1'b1;
        @(negedge clk);
        hst_rd = 1'b0;
        d = hst_rdata;
    endtask

    task automatic rd32(input int base, output logic [31:0] w);
        logic [7:0] b;
        for (int k = 0; k < 4; k++) begin
            rd(base + k, b);
            w[8*k +: 8] = b;
        end
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        for (int n = 0; n < 50; n++) begin
            rd('h480, s);
            if (!s[0]) return;
        end
    endtask

    task automatic wr_upper(input int base, input logic [31:0] a);
        for (int k = 1; k < 4; k++) wr(base + k, a[8*k +: 8]);
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=done", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] b;
        logic [31:0] w, a, d;
        int t0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11: reset state
        chk("R11 mst_req", {31'b0, mst_req}, 0);
        rd32('h474, w); chk("R11 data window", w, 0);
        rd32('h478, w); chk("R11 write window", w, 0);
        rd32('h47C, w); chk("R11 read window", w, 0);
        rd('h480, b);   chk("R11 status", {24'b0, b}, 0);
        rd('h483, b);   chk("R11 select", {24'b0, b}, 0);

        // Read cycles over several address patterns: R1, R2, R3, R7, R9
        for (int p = 0; p < 6; p++) begin
            a = 32'h0100_0000 * (p * 37 + 1) + 32'h0001_0203 * (p + 1) + 32'(p * 4);
            t0 = trig_cnt;
            rd32('h474, d);
            wr_upper('h47C, a);
            #1 chk("R1 no launch on upper bytes", trig_cnt, t0);
            rd32('h47C, w);
            chk("R1 upper bytes latched", w[31:8], a[31:8]);
            wr('h47C, a[7:0]);
            rd('h474, b); chk("R9 stale data while busy", {24'b0, b}, {24'b0, d[7:0]});
            rd('h480, b); chk("R7 busy set", {31'b0, b[0]}, 1);
            chk("R7 request held", {31'b0, mst_req}, 1);
            wait_idle();
            chk("R2 one launch", trig_cnt, t0 + 1);
            chk("R2 launch address", last_addr, a);
            chk("R3 read cycle", {31'b0, last_we}, 0);
            rd32('h474, w); chk("R3 captured word", w, mem_word(a));
            rd('h480, b); chk("R7 busy cleared", {31'b0, b[0]}, 0);
        end

        // Write cycles: R4
        for (int p = 0; p < 4; p++) begin
            a = 32'h2000_0000 + 32'(p * 32'h0011_0104);
            d = 32'hA1B2_C3D4 ^ (32'h0101_0101 * p);
            t0 = trig_cnt;
            for (int k = 0; k < 4; k++) wr('h474 + k, d[8*k +: 8]);
            wr_upper('h478, a);
            wr('h478, a[7:0]);
            wait_idle();
            chk("R4 one launch", trig_cnt, t0 + 1);
            chk("R4 write cycle", {31'b0, last_we}, 1);
            chk("R4 address", last_addr, a);
            chk("R4 data", last_wdata, d);
        end

        // R5: fixed-address repeated writes to an upper byte
        a = 32'h3344_5566;
        t0 = trig_cnt;
        for (int k = 1; k < 4; k++)
            for (int r = 0; r < 4; r++) wr('h47C + k, a[8*k +: 8]);
        #1 chk("R5 fixed writes harmless", trig_cnt, t0);
        rd32('h47C, w); chk("R5 upper value", w[31:8], a[31:8]);
        for (int r = 0; r < 3; r++) begin
            wr('h47C, a[7:0]);
            wait_idle();
            chk("R5 each idle lane-0 hit launches once", trig_cnt, t0 + r + 1);
        end

        // R6: ascending full-word write after upper bytes preloaded
        a = 32'h7788_99AA;
        wr_upper('h47C, a);
        t0 = trig_cnt;
        for (int k = 0; k < 4; k++) wr('h47C + k, a[8*k +: 8]);
        wait_idle();
        chk("R6 single launch", trig_cnt, t0 + 1);
        chk("R6 address", last_addr, a);

        // R8: launch while busy
        a = 32'h0BAD_F00C;
        wr_upper('h47C, a);
        t0 = trig_cnt;
        wr('h47C, a[7:0]);
        wr('h47C, 8'h55);
        rd('h480, b); chk("R8 overrun set", {30'b0, b[1:0]}, 3);
        rd('h47C, b); chk("R8 byte 0 unchanged", {24'b0, b}, {24'b0, a[7:0]});
        wait_idle();
        chk("R8 no extra launch", trig_cnt, t0 + 1);
        chk("R8 address kept", last_addr, a);
        wr('h480, 8'h01);
        rd('h480, b); chk("R8 write zero keeps flag", {31'b0, b[1]}, 1);
        wr('h480, 8'h02);
        rd('h480, b); chk("R8 write one clears flag", {31'b0, b[1]}, 0);

        // R10: sweep debug select including out-of-range indices
        for (int i = 0; i < DN + 3; i++) begin
            for (int r = 0; r < 4; r++) wr('h483, 8'(i));
            rd('h483, b); chk("R10 select held", {24'b0, b}, 32'(i));
            rd32('h484, w); chk("R10 debug word", w, bank_word(i));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule